// File: doc/BRIEF.md
# Prescaled Timer with Two Compare Waveform Outputs

This block is a 16-bit counter that advances on the enable pulses of a built-in prescaler. It runs in one of four waveform modes: free-running, clear on reaching a compare value, single-slope (fast) PWM, and dual-slope (phase-correct) PWM. Two compare channels, A and B, each watch the count. On a match a channel drives its waveform output as its 2-bit action field selects, and it raises a sticky match flag. In the two PWM modes the compare values are double-buffered, so a duty-cycle change takes effect only at the end of a period.

Software uses a small word-wide register port to program the block. A write to a control register can also fire a one-shot force strobe for either channel. Each output pin carries the channel's waveform only when that channel's action field is nonzero and the pin's direction enable is high. Otherwise the pin carries the plain port value.

The counter's sequencing is a two-state machine, `DIR_UP` and `DIR_DOWN`. Outside the dual-slope mode the machine stays in `DIR_UP`. In the dual-slope mode, a tick while in `DIR_UP` with the count at TOP takes the transition `turn_at_top` to `DIR_DOWN`. A tick while in `DIR_DOWN` with the count at zero takes the transition `turn_at_bottom` back to `DIR_UP`. The 4-bit mode field decodes to the named modes `WM_NORMAL` (code 0, which is also the fallback for any code not listed here), `WM_CTC` (code 4), `WM_FAST` (code 14) and `WM_PHASE` (code 10).

Top module: `wavetimer`

## Requirements
- R1: Clock select field codes: 0 stops the counter, 1 advances it on every clock, 2 advances it once in every 8 clocks, and 3 advances it once in every 64 clocks. Codes 4 to 7 also stop the counter. The count changes only on an advance or on a register write to the count.
- R2: In WM_NORMAL the count rises by one per advance and wraps from 0xFFFF to 0. That wrap sets the overflow flag (status bit 0).
- R3: In WM_CTC the count rises to the active channel A compare value, and the next advance loads 0.
- R4: In WM_FAST the count rises to the TOP register, and the next advance loads 0. That advance sets the overflow flag and the top flag (status bit 3).
- R5: In WM_PHASE the count rises to the TOP register and then falls back to 0. The advance that leaves TOP sets the top flag. The advance that leaves 0 while falling sets the overflow flag.
- R6: In the two PWM modes a compare write lands only in the buffer, which is what a read returns. The active compare value takes the buffer on the advance that leaves TOP. In the other modes a write updates both at once.
- R7: An advance taken while the count equals a channel's active compare value sets that channel's match flag (status bit 1 for A, bit 2 for B).
- R8: In WM_NORMAL and WM_CTC, the action field acts on a match as follows: 00 does nothing, 01 toggles the waveform, 10 clears it, and 11 sets it.
- R9: In WM_FAST, action 10 clears the waveform on a match and sets it on the wrap to 0. Action 11 does the opposite. Action 01 toggles on a match.
- R10: In WM_PHASE, action 10 clears the waveform on a match while rising and sets it on a match while falling. Action 11 does the opposite.
- R11: A control-A write with force bit 3 (A) or bit 2 (B) set applies the R8 action of the field written in that same write, at once. It sets no flag and leaves the count unchanged. The force bits always read as 0.
- R12: A pin carries its channel's waveform only when the channel's action field is nonzero and the pin's direction enable is 1. Otherwise it carries the port value.
- R13: Register map: 0 is control A (bits 7:6 action A, 5:4 action B, 3 and 2 force A and B, 1:0 mode bits 1:0). 1 is control B (bits 4:3 mode bits 3:2, 2:0 clock select). 2 is the count, 3 and 4 are compare A and B, 5 is TOP, and 6 is status. Everything resets to 0. Writing 1 to a status bit clears it, and a flag stays set until it is cleared that way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| port_a_val | input | 1 | Plain port value for pin A |
| port_b_val | input | 1 | Plain port value for pin B |
| dir_a | input | 1 | Direction enable of pin A |
| dir_b | input | 1 | Direction enable of pin B |
| pin_a | output | 1 | Pin A level |
| pin_b | output | 1 | Pin B level |
| flags | output | 4 | Status flags (overflow, match A, match B, top) |

## Verification
The assertions check, on every cycle, that the count holds still between advances and that the divide-by-8 enable never fires on two cycles in a row. They also check that the single-slope wrap loads zero, that the dual-slope machine turns to `DIR_DOWN` at TOP, that a PWM active compare value changes only at the reload, and that a set overflow flag stays set until it is cleared. Only the bench's scenarios can show the whole sequences: a buffered duty change taking effect one period late, the set/clear pattern on each slope, the exact advance spacing of each prescale setting, and forced actions that leave the flags and the count alone.

// File: rtl/wavetimer_pkg.sv
package wavetimer_pkg;

    typedef enum logic [1:0] {WM_NORMAL, WM_CTC, WM_FAST, WM_PHASE} wmode_e;
    typedef enum logic       {DIR_UP, DIR_DOWN} cdir_e;

    localparam logic [1:0] CM_OFF    = 2'b00;
    localparam logic [1:0] CM_TOGGLE = 2'b01;
    localparam logic [1:0] CM_CLEAR  = 2'b10;
    localparam logic [1:0] CM_SET    = 2'b11;

    localparam logic [2:0] A_CTRLA = 3'd0;
    localparam logic [2:0] A_CTRLB = 3'd1;
    localparam logic [2:0] A_CNT   = 3'd2;
    localparam logic [2:0] A_CMPA  = 3'd3;
    localparam logic [2:0] A_CMPB  = 3'd4;
    localparam logic [2:0] A_TOP   = 3'd5;
    localparam logic [2:0] A_STAT  = 3'd6;

    function automatic wmode_e decode_mode(input logic [3:0] code);
        case (code)
            4'd4:    return WM_CTC;
            4'd14:   return WM_FAST;
            4'd10:   return WM_PHASE;
            default: return WM_NORMAL;
        endcase
    endfunction

    // Plain match action: keep, toggle, clear, set.
    function automatic logic plain_action(input logic [1:0] cm, input logic cur);
        case (cm)
            CM_TOGGLE: return ~cur;
            CM_CLEAR:  return 1'b0;
            CM_SET:    return 1'b1;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler
    import wavetimer_pkg::*;
#(
    parameter int LOG_MID = 3,
    parameter int LOG_HI  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [LOG_HI-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    always_comb begin
        case (sel)
            3'd1:    tick = 1'b1;
            3'd2:    tick = &div_q[LOG_MID-1:0];
            3'd3:    tick = &div_q;
            default: tick = 1'b0;
        endcase
    end

    // R1: divide-by-8 enable is never active on consecutive cycles
    p_div_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd2 && tick) |=> (sel != 3'd2 || !tick));

endmodule

// File: rtl/wt_counter.sv
module wt_counter
    import wavetimer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wmode_e       mode,
    input  logic [W-1:0] top,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    output logic [W-1:0] cnt,
    output logic         dir_down,
    output logic         top_evt,
    output logic         bottom_evt,
    output logic         ovf_evt,
    output logic         reload_evt
);

    cdir_e        state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         at_top;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIR_UP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and events
    always_comb begin
        at_top     = (cnt_q == top);
        state_d    = (mode == WM_PHASE) ? state_q : DIR_UP;
        cnt_d      = cnt_q;
        top_evt    = 1'b0;
        bottom_evt = 1'b0;
        ovf_evt    = 1'b0;
        reload_evt = 1'b0;
        if (tick) begin
            unique case (mode)
                WM_NORMAL: begin
                    cnt_d   = cnt_q + 1'b1;
                    ovf_evt = &cnt_q;
                end
                WM_CTC: begin
                    cnt_d = at_top ? '0 : cnt_q + 1'b1;
                end
                WM_FAST: begin
                    if (at_top) begin
                        cnt_d      = '0;
                        ovf_evt    = 1'b1;
                        top_evt    = 1'b1;
                        bottom_evt = 1'b1;
                        reload_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                WM_PHASE: begin
                    unique case (state_q)
                        DIR_UP: begin
                            if (at_top) begin        // turn_at_top
                                state_d    = DIR_DOWN;
                                cnt_d      = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                                top_evt    = 1'b1;
                                reload_evt = 1'b1;
                            end else begin
                                cnt_d = cnt_q + 1'b1;
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt_q == '0) begin   // turn_at_bottom
                                state_d = DIR_UP;
                                cnt_d   = at_top ? '0 : {{(W-1){1'b0}}, 1'b1};
                                ovf_evt = 1'b1;
                            end else begin
                                cnt_d = cnt_q - 1'b1;
                            end
                        end
                    endcase
                end
            endcase
        end
        if (cnt_wr) cnt_d = cnt_wdata;
    end

    assign cnt      = cnt_q;
    assign dir_down = (state_q == DIR_DOWN);

    // R1: count holds between advances unless written
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    // R4: single-slope wrap loads zero
    p_fast_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == WM_FAST && cnt_q == top && !cnt_wr) |=> (cnt_q == '0));

    // R5: dual-slope turns downward at TOP
    p_phase_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == WM_PHASE && state_q == DIR_UP && cnt_q == top)
        |=> (state_q == DIR_DOWN));

endmodule

// File: rtl/wt_channel.sv
module wt_channel
    import wavetimer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wmode_e       mode,
    input  logic [1:0]   cm,
    input  logic         force_i,
    input  logic [1:0]   force_cm,
    input  logic [W-1:0] cnt,
    input  logic         dir_down,
    input  logic         bottom_evt,
    input  logic         reload_evt,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_act,
    output logic [W-1:0] cmp_buf,
    output logic         match_evt,
    output logic         wave
);

    logic [W-1:0] act_q, buf_q;
    logic         wave_q, wave_d;
    logic         is_pwm;

    assign is_pwm    = (mode == WM_FAST) || (mode == WM_PHASE);
    assign match_evt = tick && (cnt == act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            buf_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            if (cmp_wr) buf_q <= cmp_wdata;
            if (cmp_wr && !is_pwm)       act_q <= cmp_wdata;
            else if (is_pwm && reload_evt) act_q <= buf_q;
            wave_q <= wave_d;
        end
    end

    always_comb begin
        wave_d = wave_q;
        if (force_i) begin
            wave_d = plain_action(force_cm, wave_q);
        end else begin
            if (match_evt) begin
                if (mode == WM_PHASE) begin
                    case (cm)
                        CM_TOGGLE: wave_d = ~wave_q;
                        CM_CLEAR:  wave_d = dir_down;
                        CM_SET:    wave_d = ~dir_down;
                        default:   wave_d = wave_q;
                    endcase
                end else begin
                    wave_d = plain_action(cm, wave_q);
                end
            end
            if (mode == WM_FAST && bottom_evt) begin
                if (cm == CM_CLEAR)    wave_d = 1'b1;
                else if (cm == CM_SET) wave_d = 1'b0;
            end
        end
    end

    assign cmp_act = act_q;
    assign cmp_buf = buf_q;
    assign wave    = wave_q;

    // R6: in PWM modes the active value moves only at the reload point
    p_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && !reload_evt) |=> $stable(act_q));

endmodule

// File: rtl/wavetimer.sv
module wavetimer
    import wavetimer_pkg::*;
#(
    parameter int W       = 16,
    parameter int PRE_MID = 3,
    parameter int PRE_HI  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   reg_addr,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         port_a_val,
    input  logic         port_b_val,
    input  logic         dir_a,
    input  logic         dir_b,
    output logic         pin_a,
    output logic         pin_b,
    output logic [3:0]   flags
);

    localparam int NCH = 2;

    logic [NCH-1:0][1:0]   cm_q;
    logic [3:0]            mode_q;
    logic [2:0]            clksel_q;
    logic [W-1:0]          top_q;
    logic [3:0]            flags_q;

    wmode_e                wmode;
    logic                  tick, ctrla_wr, cnt_wr;
    logic [W-1:0]          cnt, top_val;
    logic                  dir_down, top_evt, bottom_evt, ovf_evt, reload_evt;
    logic [NCH-1:0]        force_v, match_v, wave_v, port_v, dir_v, pin_v;
    logic [NCH-1:0][1:0]   force_cm_v;
    logic [NCH-1:0][W-1:0] act_v, buf_v;

    assign wmode    = decode_mode(mode_q);
    assign ctrla_wr = reg_wr && (reg_addr == A_CTRLA);
    assign cnt_wr   = reg_wr && (reg_addr == A_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_q     <= '0;
            mode_q   <= '0;
            clksel_q <= '0;
            top_q    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRLA: begin
                    cm_q[0]     <= reg_wdata[7:6];
                    cm_q[1]     <= reg_wdata[5:4];
                    mode_q[1:0] <= reg_wdata[1:0];
                end
                A_CTRLB: begin
                    mode_q[3:2] <= reg_wdata[4:3];
                    clksel_q    <= reg_wdata[2:0];
                end
                A_TOP:   top_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Sticky flags: events set, write-one clears, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~((reg_wr && reg_addr == A_STAT) ? reg_wdata[3:0] : 4'h0))
                     | {top_evt, match_v[1], match_v[0], ovf_evt};
        end
    end

    always_comb begin
        unique case (wmode)
            WM_CTC:            top_val = act_v[0];
            WM_FAST, WM_PHASE: top_val = top_q;
            default:           top_val = {W{1'b1}};
        endcase
    end

    wt_prescaler #(.LOG_MID(PRE_MID), .LOG_HI(PRE_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(clksel_q), .tick(tick)
    );

    wt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(wmode), .top(top_val),
        .cnt_wr(cnt_wr), .cnt_wdata(reg_wdata), .cnt(cnt), .dir_down(dir_down),
        .top_evt(top_evt), .bottom_evt(bottom_evt), .ovf_evt(ovf_evt),
        .reload_evt(reload_evt)
    );

    assign port_v = {port_b_val, port_a_val};
    assign dir_v  = {dir_b, dir_a};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [2:0] CADDR = A_CMPA + 3'(g);

        assign force_v[g]    = ctrla_wr && reg_wdata[3-g];
        assign force_cm_v[g] = reg_wdata[7-2*g -: 2];

        wt_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .mode(wmode), .cm(cm_q[g]),
            .force_i(force_v[g]), .force_cm(force_cm_v[g]), .cnt(cnt),
            .dir_down(dir_down), .bottom_evt(bottom_evt), .reload_evt(reload_evt),
            .cmp_wr(reg_wr && reg_addr == CADDR), .cmp_wdata(reg_wdata),
            .cmp_act(act_v[g]), .cmp_buf(buf_v[g]), .match_evt(match_v[g]),
            .wave(wave_v[g])
        );

        assign pin_v[g] = (cm_q[g] != CM_OFF && dir_v[g]) ? wave_v[g] : port_v[g];
    end

    assign pin_a = pin_v[0];
    assign pin_b = pin_v[1];
    assign flags = flags_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRLA: reg_rdata[7:0] = {cm_q[0], cm_q[1], 2'b00, mode_q[1:0]};
            A_CTRLB: reg_rdata[4:0] = {mode_q[3:2], clksel_q};
            A_CNT:   reg_rdata = cnt;
            A_CMPA:  reg_rdata = buf_v[0];
            A_CMPB:  reg_rdata = buf_v[1];
            A_TOP:   reg_rdata = top_q;
            A_STAT:  reg_rdata[3:0] = flags_q;
            default: reg_rdata = '0;
        endcase
    end

    // R13: overflow flag stays set until a write-one clears it
    p_flag_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(reg_wr && reg_addr == A_STAT && reg_wdata[0])) |=> flags_q[0]);

    // R11: a force strobe alone never sets a match flag
    p_force_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (force_v[0] && !tick && !flags_q[1] && !(reg_wr && reg_addr == A_STAT))
        |=> !flags_q[1]);

endmodule

// File: tb/sim_wavetimer.sv
module sim_wavetimer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        port_a_val = 1'b0, port_b_val = 1'b0, dir_a = 1'b0, dir_b = 1'b0;
    logic        pin_a, pin_b;
    logic [3:0]  flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wavetimer u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_a_val(port_a_val),
        .port_b_val(port_b_val), .dir_a(dir_a), .dir_b(dir_b), .pin_a(pin_a),
        .pin_b(pin_b), .flags(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        port_a_val = 1'b1; port_b_val = 1'b1;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R13 reset register value", v, 0);
        end
        chk("R12 reset pin A follows port", pin_a, 1);
        chk("R12 reset pin B follows port", pin_b, 1);
        port_a_val = 1'b0; port_b_val = 1'b0;
    endtask

    task automatic t_normal();
        logic [15:0] v;
        wr(1, 16'h0000); wr(0, 16'h0000); wr(2, 16'hFFFE); wr(6, 16'h000F);
        wr(1, 16'h0001);
        step(1); rd(2, v);
        chk("R2 count before wrap", v, 16'hFFFF);
        chk("R2 no overflow yet", flags[0], 0);
        step(1); rd(2, v);
        chk("R2 count wraps to zero", v, 0);
        rd(6, v);
        chk("R2 overflow flag set", v[0], 1);
        wr(1, 16'h0000);
        step(3);
        chk("R13 overflow flag sticky", flags[0], 1);
        wr(6, 16'h0001);
        chk("R13 write-one clears flag", flags[0], 0);
    endtask

    task automatic t_ctc();
        logic [15:0] v;
        dir_a = 1'b1; dir_b = 1'b1;
        wr(3, 16'd3); wr(4, 16'd1); wr(2, 16'd0); wr(6, 16'h000F);
        wr(0, 16'h0070);
        wr(1, 16'h0009);
        step(2);
        chk("R8 set action on match B", pin_b, 1);
        step(2); rd(2, v);
        chk("R3 count returns to zero after compare A", v, 0);
        chk("R8 toggle action on match A", pin_a, 1);
        chk("R7 match flags A and B", flags, 4'b0110);
        step(4); rd(2, v);
        chk("R3 second period", v, 0);
        chk("R8 second toggle", pin_a, 0);
        wr(1, 16'h0020);
        dir_a = 1'b0; port_a_val = 1'b1;
        #1;
        chk("R12 direction off gives port value", pin_a, 1);
        dir_a = 1'b1;
        wr(0, 16'h0030);
        chk("R12 action off gives port value", pin_a, 1);
        port_a_val = 1'b0;
    endtask

    task automatic t_force();
        logic [15:0] v, c0;
        wr(1, 16'h0000); wr(6, 16'h000F);
        rd(2, c0);
        wr(0, 16'h00C8);
        chk("R11 force set drives pin A high", pin_a, 1);
        chk("R11 force sets no flag", flags, 0);
        rd(2, v);
        chk("R11 force leaves count", v, c0);
        rd(0, v);
        chk("R11 force bits read zero", v, 16'h00C0);
        wr(0, 16'h0048);
        chk("R11 force toggle drives pin A low", pin_a, 0);
    endtask

    task automatic t_fast();
        logic [15:0] v;
        wr(1, 16'h0000); wr(3, 16'd4); wr(4, 16'd6); wr(2, 16'd0); wr(5, 16'd9);
        wr(0, 16'h00B2);
        wr(1, 16'h0018);
        wr(3, 16'd7);
        rd(3, v);
        chk("R6 compare read returns buffer", v, 7);
        wr(6, 16'h000F);
        wr(1, 16'h0019);
        step(10); rd(2, v);
        chk("R4 fast count wraps after TOP", v, 0);
        chk("R9 set at bottom for clear action", pin_a, 1);
        chk("R9 clear at bottom for set action", pin_b, 0);
        chk("R4 overflow and top flags", flags, 4'b1111);
        step(5);
        chk("R6 old compare no longer acts", pin_a, 1);
        step(3);
        chk("R9 clear on new compare match", pin_a, 0);
        chk("R9 set on match B", pin_b, 1);
    endtask

    task automatic t_phase();
        logic [15:0] v;
        wr(1, 16'h0000); wr(3, 16'd2); wr(2, 16'd0); wr(5, 16'd5); wr(6, 16'h000F);
        wr(0, 16'h0082);
        wr(1, 16'h0011);
        step(3); rd(2, v);
        chk("R5 rising count", v, 3);
        chk("R10 clear on rising match", pin_a, 0);
        step(3); rd(2, v);
        chk("R5 turns down after TOP", v, 4);
        chk("R5 top flag", flags[3], 1);
        chk("R5 no overflow at TOP", flags[0], 0);
        step(3); rd(2, v);
        chk("R5 falling count", v, 1);
        chk("R10 set on falling match", pin_a, 1);
        step(1); rd(2, v);
        chk("R5 reaches bottom", v, 0);
        chk("R5 overflow not yet", flags[0], 0);
        step(1); rd(2, v);
        chk("R5 turns up at bottom", v, 1);
        chk("R5 overflow at bottom", flags[0], 1);
    endtask

    task automatic t_prescale(input logic [15:0] sel, input int div, input string tag);
        logic [15:0] c0, v;
        int n = 0;
        wr(1, 16'h0000); wr(0, 16'h0000); wr(2, 16'd0);
        wr(1, sel);
        rd(2, c0);
        while (n < 200) begin
            step(1); rd(2, v);
            n++;
            if (v != c0) break;
        end
        c0 = v;
        step(div - 1); rd(2, v);
        chk(tag, v, c0);
        step(1); rd(2, v);
        chk(tag, v, c0 + 1);
    endtask

    task automatic t_stopped();
        logic [15:0] c0, v;
        wr(1, 16'h0005);
        rd(2, c0);
        step(100); rd(2, v);
        chk("R1 select code 5 stops count", v, c0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_ctc();
        t_force();
        t_fast();
        t_phase();
        t_prescale(16'h0002, 8, "R1 divide by 8 spacing");
        t_prescale(16'h0003, 64, "R1 divide by 64 spacing");
        t_stopped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule